// File: doc/BRIEF.md
# Video Memory Read Prefetch Port

This block is the processor's read window into a video memory built from 16-bit words. It keeps a 15-bit word address and a 16-bit prefetch register. The processor sets the address one byte at a time and reads the prefetch register through two byte strobes, one for the low byte and one for the high byte. A byte read always returns what the prefetch register already holds. Reads are therefore one word behind the address, except for the first read after the address is loaded.

A mode input chooses which byte read moves the address forward, and a 2-bit step field chooses the size of the move. When a read moves the address, the block first fetches the word at the unchanged address into the prefetch register and only then advances the address. Loading either address byte starts a fetch of the word at the new address. Data writes are handled elsewhere, but their strobes are routed here so that they advance the address under the same mode and step rules. A data write never fetches and never changes the prefetch register.

The block drives a synchronous memory read port with one cycle of latency. While a fetch is in flight, the block reports busy and ignores every processor strobe.

Top module: `vram_prefetch_port`

## Requirements
- R1: After reset the address is 0, the prefetch register is 0, `busy` is low and `mem_rd_en` is low.
- R2: In any cycle with `rd_lo` high, `rd_data` shows prefetch bits 7:0. In a cycle with only `rd_hi` high, it shows bits 15:8. The value is the register content before any reload that the read may cause.
- R3: An accepted `addr_lo_wr` loads address bits 7:0 from `wr_byte`. An accepted `addr_hi_wr` loads bits 14:8 from `wr_byte[6:0]`. In the next cycle `mem_rd_en` is high with the new address on `mem_rd_addr`, and the word returned lands in the prefetch register two cycles after that request cycle.
- R4: A byte read triggers an increment when it is `rd_lo` with `inc_on_hi`=0, or `rd_hi` with `inc_on_hi`=1. In the next cycle `mem_rd_en` is high with the old address, and the address has moved forward by the step.
- R5: A byte read that does not trigger an increment issues no memory read and leaves the address and the prefetch register unchanged.
- R6: The step field `step_sel` gives 1 word for 0, 32 words for 1, and 128 words for 2 or 3. The address wraps modulo 2^15.
- R7: A data write byte strobe (`dwr_lo` or `dwr_hi`) advances the address by the step when it matches `inc_on_hi` in the same way as R4. It never issues a memory read and never changes the prefetch register.
- R8: `busy` is high for exactly the two cycles after an accepted fetch trigger: the request cycle and the data cycle. While `busy` is high, every address, read and data-write strobe is ignored.
- R9: When several strobes arrive in one cycle, only the highest-ranked group takes effect. The ranking is address write, then byte read (`rd_lo` over `rd_hi`), then data write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| addr_lo_wr | input | 1 | Load address low byte from `wr_byte` |
| addr_hi_wr | input | 1 | Load address high bits from `wr_byte` |
| wr_byte | input | 8 | Address byte value |
| rd_lo | input | 1 | Processor reads prefetch low byte |
| rd_hi | input | 1 | Processor reads prefetch high byte |
| rd_data | output | 8 | Byte returned to the processor |
| dwr_lo | input | 1 | Data write low-byte strobe (address effect only) |
| dwr_hi | input | 1 | Data write high-byte strobe (address effect only) |
| inc_on_hi | input | 1 | 0: low-byte access advances, 1: high-byte access advances |
| step_sel | input | 2 | Increment size select |
| busy | output | 1 | Fetch in flight, strobes ignored |
| mem_rd_en | output | 1 | Memory read request |
| mem_rd_addr | output | 15 | Memory word address |
| mem_rd_data | input | 16 | Memory read data, valid one cycle after request |

## Verification
The central overlap is a byte read that triggers an increment. In that single cycle the old prefetch byte goes to the processor, the fetch address is captured from the unchanged address register, and the address advances. The bench checks `rd_data` against the modelled old contents, then checks `mem_rd_addr` in the request cycle against the pre-increment address. A later fetch then reveals the advanced address. The second overlap is a new strobe arriving during an in-flight fetch, or several strobes arriving in one cycle. The bench issues these on purpose and judges them by the next fetch address and by the bytes read back.

// File: rtl/vpp_pkg.sv
// Package: shared step encoding for the video memory prefetch port.
// Assumes the step field is two bits wide; codes 2 and 3 both select the largest step.
package vpp_pkg;

    typedef enum logic [1:0] {
        STEP_UNIT  = 2'd0,
        STEP_ROW   = 2'd1,
        STEP_BLOCK = 2'd2,
        STEP_ALT   = 2'd3
    } step_code_e;

    // Map a step code to its word count
    function automatic int unsigned step_words(
        input logic [1:0]  code,
        input int unsigned small_w,
        input int unsigned mid_w,
        input int unsigned large_w
    );
        case (step_code_e'(code))
            STEP_UNIT: return small_w;
            STEP_ROW:  return mid_w;
            default:   return large_w;
        endcase
    endfunction

endpackage

// File: rtl/vpp_addr_reg.sv
// Word address register for the prefetch port.
// Loads byte-wise from the processor, or advances by a selected step.
// Assumes at most one of load and advance is requested per cycle; the top resolves priority.
// addr_wr_val presents the address value after the requested byte load, for fetch launch.
module vpp_addr_reg #(
    parameter int unsigned ADDR_W  = 15,
    parameter int unsigned BYTE_W  = 8,
    parameter int unsigned STEP_S  = 1,
    parameter int unsigned STEP_M  = 32,
    parameter int unsigned STEP_L  = 128
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ld_lo,
    input  logic              ld_hi,
    input  logic [BYTE_W-1:0] ld_byte,
    input  logic              adv,
    input  logic [1:0]        step_sel,
    output logic [ADDR_W-1:0] addr_q,
    output logic [ADDR_W-1:0] addr_wr_val
);
    import vpp_pkg::*;

    localparam int unsigned HI_W = ADDR_W - BYTE_W;

    logic [ADDR_W-1:0] step_v;

    // Select the increment amount from the step code
    always_comb begin
        step_v = ADDR_W'(step_words(step_sel, STEP_S, STEP_M, STEP_L));
    end

    // Merge the incoming byte into the current address
    always_comb begin
        addr_wr_val = addr_q;
        if (ld_lo) begin
            addr_wr_val[BYTE_W-1:0] = ld_byte;
        end
        if (ld_hi) begin
            addr_wr_val[ADDR_W-1:BYTE_W] = ld_byte[HI_W-1:0];
        end
    end

    // Hold, load or advance the address
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q <= '0;
        end else if (ld_lo || ld_hi) begin
            addr_q <= addr_wr_val;
        end else if (adv) begin
            addr_q <= addr_q + step_v;
        end
    end

endmodule

// File: rtl/vpp_fetch_ctrl.sv
// Fetch sequencer for the prefetch port.
// A trigger captures the fetch address. The next cycle issues the memory read,
// and the cycle after that the returned word is loaded.
// Assumes memory read latency of exactly one cycle and triggers only while not busy.
module vpp_fetch_ctrl #(
    parameter int unsigned ADDR_W = 15
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              trigger,
    input  logic [ADDR_W-1:0] trig_addr,
    output logic              busy,
    output logic              mem_rd_en,
    output logic [ADDR_W-1:0] mem_rd_addr,
    output logic              load_en
);
    logic              req_q;
    logic              wait_q;
    logic [ADDR_W-1:0] faddr_q;

    // Advance the two-stage request pipeline
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            req_q  <= 1'b0;
            wait_q <= 1'b0;
        end else begin
            req_q  <= trigger;
            wait_q <= req_q;
        end
    end

    // Capture the address to fetch at trigger time
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            faddr_q <= '0;
        end else if (trigger) begin
            faddr_q <= trig_addr;
        end
    end

    // Drive memory request and status
    always_comb begin
        busy        = req_q | wait_q;
        mem_rd_en   = req_q;
        mem_rd_addr = faddr_q;
        load_en     = wait_q;
    end

endmodule

// File: rtl/vpp_prefetch_buf.sv
// Prefetch register and byte read mux.
// The read byte always comes from the current register contents; a reload
// only becomes visible in the cycle after load_en.
// Assumes WORD_W is exactly two bytes.
module vpp_prefetch_buf #(
    parameter int unsigned WORD_W = 16,
    parameter int unsigned BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_en,
    input  logic [WORD_W-1:0] load_word,
    input  logic              sel_hi,
    output logic [BYTE_W-1:0] rd_byte
);
    logic [WORD_W-1:0] pf_q;

    // Load the fetched word
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pf_q <= '0;
        end else if (load_en) begin
            pf_q <= load_word;
        end
    end

    // Select the requested byte
    always_comb begin
        rd_byte = sel_hi ? pf_q[WORD_W-1:BYTE_W] : pf_q[BYTE_W-1:0];
    end

endmodule

// File: rtl/vram_prefetch_port.sv
// Processor read port into a 16-bit word video memory.
// Resolves strobe priority (address write, then read, then data write),
// launches fetches on address loads and on advancing reads, and ignores all strobes while busy.
// Assumes a synchronous memory with one cycle of read latency.
module vram_prefetch_port #(
    parameter int unsigned ADDR_W = 15,
    parameter int unsigned WORD_W = 16,
    parameter int unsigned BYTE_W = 8,
    parameter int unsigned STEP_S = 1,
    parameter int unsigned STEP_M = 32,
    parameter int unsigned STEP_L = 128
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              addr_lo_wr,
    input  logic              addr_hi_wr,
    input  logic [BYTE_W-1:0] wr_byte,
    input  logic              rd_lo,
    input  logic              rd_hi,
    output logic [BYTE_W-1:0] rd_data,
    input  logic              dwr_lo,
    input  logic              dwr_hi,
    input  logic              inc_on_hi,
    input  logic [1:0]        step_sel,
    output logic              busy,
    output logic              mem_rd_en,
    output logic [ADDR_W-1:0] mem_rd_addr,
    input  logic [WORD_W-1:0] mem_rd_data
);
    logic              idle;
    logic              acc_awr;
    logic              acc_rd;
    logic              acc_dwr;
    logic              rd_sel_hi;
    logic              rd_adv;
    logic              dwr_adv;
    logic              trigger;
    logic              load_en;
    logic [ADDR_W-1:0] addr_q;
    logic [ADDR_W-1:0] addr_wr_val;
    logic [ADDR_W-1:0] trig_addr;

    // Rank simultaneous strobes and gate them with busy
    always_comb begin
        idle      = ~busy;
        acc_awr   = idle & (addr_lo_wr | addr_hi_wr);
        acc_rd    = idle & ~(addr_lo_wr | addr_hi_wr) & (rd_lo | rd_hi);
        acc_dwr   = idle & ~(addr_lo_wr | addr_hi_wr) & ~(rd_lo | rd_hi) & (dwr_lo | dwr_hi);
        rd_sel_hi = ~rd_lo;
        rd_adv    = acc_rd & (rd_sel_hi == inc_on_hi);
        dwr_adv   = acc_dwr & (inc_on_hi ? dwr_hi : dwr_lo);
        trigger   = acc_awr | rd_adv;
        trig_addr = acc_awr ? addr_wr_val : addr_q;
    end

    vpp_addr_reg #(
        .ADDR_W (ADDR_W),
        .BYTE_W (BYTE_W),
        .STEP_S (STEP_S),
        .STEP_M (STEP_M),
        .STEP_L (STEP_L)
    ) u_addr (
        .clk         (clk),
        .rst_n       (rst_n),
        .ld_lo       (acc_awr & addr_lo_wr),
        .ld_hi       (acc_awr & addr_hi_wr),
        .ld_byte     (wr_byte),
        .adv         (rd_adv | dwr_adv),
        .step_sel    (step_sel),
        .addr_q      (addr_q),
        .addr_wr_val (addr_wr_val)
    );

    vpp_fetch_ctrl #(
        .ADDR_W (ADDR_W)
    ) u_fetch (
        .clk         (clk),
        .rst_n       (rst_n),
        .trigger     (trigger),
        .trig_addr   (trig_addr),
        .busy        (busy),
        .mem_rd_en   (mem_rd_en),
        .mem_rd_addr (mem_rd_addr),
        .load_en     (load_en)
    );

    vpp_prefetch_buf #(
        .WORD_W (WORD_W),
        .BYTE_W (BYTE_W)
    ) u_buf (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_en   (load_en),
        .load_word (mem_rd_data),
        .sel_hi    (rd_hi & ~rd_lo),
        .rd_byte   (rd_data)
    );

endmodule

// File: rtl/vpp_checker.sv
// Assertion checker for vram_prefetch_port, attached by bind.
// Observes ports and the address register; it drives nothing.
module vpp_checker #(
    parameter int unsigned ADDR_W = 15
) (
    input logic              clk,
    input logic              rst_n,
    input logic              addr_lo_wr,
    input logic              addr_hi_wr,
    input logic              rd_lo,
    input logic              rd_hi,
    input logic              dwr_lo,
    input logic              dwr_hi,
    input logic              inc_on_hi,
    input logic [1:0]        step_sel,
    input logic              busy,
    input logic              mem_rd_en,
    input logic [ADDR_W-1:0] mem_rd_addr,
    input logic [ADDR_W-1:0] addr_q
);
    logic              c_awr;
    logic              c_rd_go;
    logic              c_rd_stay;
    logic              c_dwr;
    logic [ADDR_W-1:0] c_step;

    // Classify the accepted strobe independently of the design's decode
    always_comb begin
        c_awr     = !busy && (addr_lo_wr || addr_hi_wr);
        c_rd_go   = !busy && !addr_lo_wr && !addr_hi_wr &&
                    ((rd_lo && !inc_on_hi) || (!rd_lo && rd_hi && inc_on_hi));
        c_rd_stay = !busy && !addr_lo_wr && !addr_hi_wr && (rd_lo || rd_hi) && !c_rd_go;
        c_dwr     = !busy && !addr_lo_wr && !addr_hi_wr && !rd_lo && !rd_hi && (dwr_lo || dwr_hi);
        c_step    = (step_sel == 2'd0) ? ADDR_W'(1) :
                    (step_sel == 2'd1) ? ADDR_W'(32) : ADDR_W'(128);
    end

    AST_ADDR_WRITE_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
        c_awr |=> mem_rd_en && (mem_rd_addr == addr_q)); // R3

    AST_READ_FETCH_OLD: assert property (@(posedge clk) disable iff (!rst_n)
        c_rd_go |=> mem_rd_en && (mem_rd_addr == $past(addr_q))); // R4

    AST_READ_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        c_rd_go |=> addr_q == $past(addr_q) + $past(c_step)); // R6

    AST_STAY_READ_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        c_rd_stay |=> !mem_rd_en && $stable(addr_q)); // R5

    AST_DATA_WRITE_NO_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
        c_dwr |=> !mem_rd_en); // R7

    AST_REQ_IS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_en |-> busy); // R8

    AST_REQ_THEN_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_en |=> busy && !mem_rd_en); // R8

    AST_BUSY_FREEZES_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(addr_q)); // R8

endmodule

bind vram_prefetch_port vpp_checker #(.ADDR_W(ADDR_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .addr_lo_wr  (addr_lo_wr),
    .addr_hi_wr  (addr_hi_wr),
    .rd_lo       (rd_lo),
    .rd_hi       (rd_hi),
    .dwr_lo      (dwr_lo),
    .dwr_hi      (dwr_hi),
    .inc_on_hi   (inc_on_hi),
    .step_sel    (step_sel),
    .busy        (busy),
    .mem_rd_en   (mem_rd_en),
    .mem_rd_addr (mem_rd_addr),
    .addr_q      (addr_q)
);

// File: tb/vram_prefetch_port_bench.sv
// Bench for vram_prefetch_port: directed corner cases plus seeded random strobes,
// checked against a bench-side model of address and prefetch contents.
module vram_prefetch_port_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        addr_lo_wr = 1'b0, addr_hi_wr = 1'b0;
    logic [7:0]  wr_byte = '0;
    logic        rd_lo = 1'b0, rd_hi = 1'b0;
    logic [7:0]  rd_data;
    logic        dwr_lo = 1'b0, dwr_hi = 1'b0;
    logic        inc_on_hi = 1'b0;
    logic [1:0]  step_sel = 2'd0;
    logic        busy;
    logic        mem_rd_en;
    logic [14:0] mem_rd_addr;
    logic [15:0] mem_rd_data;

    int checks = 0;
    int errors = 0;

    logic [14:0] m_addr = '0;
    logic [15:0] m_pf = '0;

    always #5 clk = ~clk;

    vram_prefetch_port u_vram_prefetch_port (
        .clk(clk), .rst_n(rst_n),
        .addr_lo_wr(addr_lo_wr), .addr_hi_wr(addr_hi_wr), .wr_byte(wr_byte),
        .rd_lo(rd_lo), .rd_hi(rd_hi), .rd_data(rd_data),
        .dwr_lo(dwr_lo), .dwr_hi(dwr_hi),
        .inc_on_hi(inc_on_hi), .step_sel(step_sel),
        .busy(busy), .mem_rd_en(mem_rd_en), .mem_rd_addr(mem_rd_addr),
        .mem_rd_data(mem_rd_data)
    );

    // Memory content pattern
    function automatic logic [15:0] word_at(input logic [14:0] a);
        return 16'({1'b0, a} * 16'd40503) ^ 16'hC3A5;
    endfunction

    function automatic logic [14:0] step_of(input logic [1:0] s);
        return (s == 2'd0) ? 15'd1 : (s == 2'd1) ? 15'd32 : 15'd128;
    endfunction

    // Synchronous memory model, one cycle latency
    logic [15:0] mem_q = '0;
    always @(posedge clk) if (mem_rd_en) mem_q <= word_at(mem_rd_addr);
    assign mem_rd_data = mem_q;

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic clear_strobes();
        addr_lo_wr = 0; addr_hi_wr = 0; rd_lo = 0; rd_hi = 0; dwr_lo = 0; dwr_hi = 0;
    endtask

    // One operation: drive at a negedge, check through the request and data cycles
    task automatic do_op(input bit awl, input bit awh, input bit rl, input bit rh,
                         input bit dl, input bit dh, input logic [7:0] b, input string tag);
        bit          fetch = 0;
        logic [14:0] faddr = '0;
        addr_lo_wr = awl; addr_hi_wr = awh; rd_lo = rl; rd_hi = rh;
        dwr_lo = dl; dwr_hi = dh; wr_byte = b;
        #1;
        if (rl) check({"R2 low byte ", tag}, rd_data, m_pf[7:0]);
        else if (rh) check({"R2 high byte ", tag}, rd_data, m_pf[15:8]);
        if (awl || awh) begin
            if (awl) m_addr[7:0] = b;
            if (awh) m_addr[14:8] = b[6:0];
            fetch = 1; faddr = m_addr;
        end else if (rl || rh) begin
            if ((!rl) == inc_on_hi) begin
                fetch = 1; faddr = m_addr; m_addr = m_addr + step_of(step_sel);
            end
        end else if (dl || dh) begin
            if (inc_on_hi ? dh : dl) m_addr = m_addr + step_of(step_sel);
        end
        @(negedge clk);
        clear_strobes();
        check({"R8 request ", tag}, mem_rd_en, fetch);
        if (fetch) check({"R3/R4 fetch address ", tag}, mem_rd_addr, faddr);
        @(negedge clk);
        check({"R8 busy data cycle ", tag}, busy, fetch);
        @(negedge clk);
        if (fetch) m_pf = word_at(faddr);
        check({"R8 busy released ", tag}, busy, 0);
    endtask

    task automatic set_addr(input logic [14:0] a);
        do_op(1, 0, 0, 0, 0, 0, a[7:0], "R3 load lo");
        do_op(0, 1, 0, 0, 0, 0, {1'b0, a[14:8]}, "R3 load hi");
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin : main
        void'($urandom(32'd20240613));
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1 reset state
        check("R1 busy", busy, 0);
        check("R1 mem_rd_en", mem_rd_en, 0);
        check("R1 prefetch low", rd_data, 8'h00);
        rd_hi = 1; #1;
        check("R1 prefetch high", rd_data, 8'h00);
        rd_hi = 0;
        @(negedge clk);

        // R3/R4 lag: first read after load returns the word at the address, later reads lag
        inc_on_hi = 0; step_sel = 2'd0;
        set_addr(15'h1234);
        do_op(0, 0, 1, 0, 0, 0, 8'h00, "R4 first read");
        do_op(0, 0, 1, 0, 0, 0, 8'h00, "R4 lagging read");
        check("R4 lagging data", rd_data, word_at(15'h1235) & 16'hFF);

        // R5 non-advancing read in low mode
        do_op(0, 0, 0, 1, 0, 0, 8'h00, "R5 stay read");
        do_op(0, 0, 0, 1, 0, 0, 8'h00, "R5 stay read again");

        // R6 wrap with largest step, high-byte mode
        inc_on_hi = 1; step_sel = 2'd3;
        set_addr(15'h7FFF);
        do_op(0, 0, 0, 1, 0, 0, 8'h00, "R6 wrap read");
        do_op(0, 0, 0, 1, 0, 0, 8'h00, "R6 after wrap");
        check("R6 wrapped address", m_addr, 15'h00FF);

        // R7 data writes advance without fetch
        step_sel = 2'd1;
        do_op(0, 0, 0, 0, 0, 1, 8'h00, "R7 data write hi");
        do_op(0, 0, 0, 0, 1, 0, 8'h00, "R7 data write lo no move");
        do_op(0, 0, 0, 1, 0, 0, 8'h00, "R7 read after writes");

        // R9 priority: address write with read, read with data write
        inc_on_hi = 0; step_sel = 2'd0;
        do_op(1, 0, 1, 0, 0, 0, 8'h40, "R9 addr over read");
        do_op(0, 0, 1, 0, 1, 0, 8'h00, "R9 read over data write");
        do_op(0, 0, 1, 1, 0, 0, 8'h00, "R9 low over high");

        // R8 strobes during busy are dropped
        addr_lo_wr = 1; wr_byte = 8'h10;
        @(negedge clk);
        m_addr[7:0] = 8'h10;
        addr_lo_wr = 0; rd_lo = 1; dwr_lo = 1; addr_hi_wr = 1; wr_byte = 8'h55;
        @(negedge clk);
        clear_strobes();
        check("R8 busy during data", busy, 1);
        @(negedge clk);
        m_pf = word_at(m_addr);
        do_op(0, 0, 1, 0, 0, 0, 8'h00, "R8 ignored strobes");

        // Random phase
        for (int i = 0; i < 400; i++) begin
            int k = $urandom_range(0, 9);
            inc_on_hi = 1'($urandom_range(0, 1));
            step_sel  = 2'($urandom_range(0, 3));
            case (k)
                0: do_op(1, 0, 0, 0, 0, 0, 8'($urandom), "R3 rnd lo");
                1: do_op(0, 1, 0, 0, 0, 0, 8'($urandom), "R3 rnd hi");
                2, 3: do_op(0, 0, 1, 0, 0, 0, 8'h00, "R4 rnd read lo");
                4, 5: do_op(0, 0, 0, 1, 0, 0, 8'h00, "R4 rnd read hi");
                6: do_op(0, 0, 0, 0, 1, 0, 8'h00, "R7 rnd dwr lo");
                7: do_op(0, 0, 0, 0, 0, 1, 8'h00, "R7 rnd dwr hi");
                8: do_op(1, 0, 0, 1, 1, 0, 8'($urandom), "R9 rnd mix");
                default: do_op(0, 0, 1, 1, 1, 1, 8'h00, "R9 rnd read mix");
            endcase
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule